// File: doc/BRIEF.md
# Shared-Pin GPIO Bank with Resource Routing

A bank of bidirectional pins, each of which is either lent to an LCD segment driver or used as general-purpose I/O. In I/O mode a direction bit chooses whether the block drives the pin from a stored data bit or only samples it. Every pin has a 3-bit resource selector. When the pin is a GPIO input, the selector can route its synchronised level to one of two counter clock lines. It can instead raise a one-cycle pulse on a high-priority or a low-priority interrupt line, on a rising or a falling edge.

Each pin owns one 6-bit configuration word, and a register port gives access to it. Writes carry a per-bit mask, so software can change one field of a word without touching the others. This matters because segment control and I/O control share the same word. Reads return the word, with the data bit replaced by the live pin level whenever the pin is an input. The LCD waveform generator, the counters and the interrupt controller sit outside this block.

Top module: `gpio_bank`

## Requirements
- R1: After reset every configuration word reads zero: GPIO function, input direction, selector 0. `pad_oe`, `cnt_clk`, `irq_hi` and `irq_lo` are all low.
- R2: With bit 4 of a pin's word set (LCD function), `pad_out` and `pad_oe` of that pin follow `lcd_seg_out` and `lcd_seg_oe` in the same cycle. The pin's selector then routes nothing.
- R3: With bit 4 clear, `pad_oe` of the pin equals bit 3 (1 = output, 0 = input) and `pad_out` equals bit 5, from the cycle after the write.
- R4: A write changes only the word bits whose `wr_mask` bit is 1. A write with an all-zero mask changes nothing.
- R5: Read data bits [4:0] hold the stored fields. Bit 5 holds the stored data bit for an output pin. For an input pin it holds the pin level delayed by two clock edges of synchronisation.
- R6: Selector 2 drives `cnt_clk[0]` and selector 3 drives `cnt_clk[1]` with the synchronised level. Each output is registered, so it shows a pin change three edges later.
- R7: Selector 4 gives a one-cycle pulse on `irq_hi`, and selector 5 gives one on `irq_lo`, on a rising pin edge. The pulse is visible three edges after the pin change.
- R8: Selector 6 gives a one-cycle pulse on `irq_hi`, and selector 7 gives one on `irq_lo`, on a falling pin edge, with the same latency.
- R9: Selector 0 and the reserved selector 1 route nothing.
- R10: When several pins select the same resource, their contributions are OR-combined. Edges that arrive together yield one pulse.
- R11: Only pins in GPIO mode with input direction are routed. An output pin with a routing selector drives no resource.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Pin index of the word to write |
| wr_data | input | 6 | Write data: [5] data, [4] LCD function, [3] direction, [2:0] selector |
| wr_mask | input | 6 | Per-bit write enable |
| rd_addr | input | ADDR_W | Pin index to read |
| rd_data | output | 6 | Configuration word with the live level in bit 5 for input pins |
| pad_in | input | NUM_PINS | Asynchronous pin input levels |
| pad_out | output | NUM_PINS | Pin output values |
| pad_oe | output | NUM_PINS | Pin output enables |
| lcd_seg_out | input | NUM_PINS | Segment driver output values |
| lcd_seg_oe | input | NUM_PINS | Segment driver output enables |
| cnt_clk | output | 2 | Counter 0 and counter 1 clock lines |
| irq_hi | output | 1 | High-priority interrupt pulse |
| irq_lo | output | 1 | Low-priority interrupt pulse |

## Verification
The bench sweeps all eight selector codes on every pin. For each combination it toggles the pin and checks every resource output one cycle before, at, and after the expected three-edge latency. This catches swapped codes, a reserved code that routes something, rising and falling edges mixed up, and a pulse that lasts more than one cycle. Masked writes are checked by clearing a single bit and then writing with an empty mask. A design that did a whole-word write would flip the direction or the data pin. An LCD pin and an output pin both carry interrupt selectors while their input toggles, so a design that forgot to gate routing would fire `irq_hi` or `cnt_clk`. Simultaneous edges on two pins must give a single pulse, and a reset in the middle of a run must clear every driven pin.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        RS_NONE    = 3'd0,
        RS_RSVD    = 3'd1,
        RS_CNT0    = 3'd2,
        RS_CNT1    = 3'd3,
        RS_HI_RISE = 3'd4,
        RS_LO_RISE = 3'd5,
        RS_HI_FALL = 3'd6,
        RS_LO_FALL = 3'd7
    } res_sel_e;

    // Word layout: [5] data, [4] LCD function, [3] direction, [2:0] selector
    typedef struct packed {
        logic     dout;
        logic     lcd;
        logic     dir;
        res_sel_e sel;
    } pin_cfg_t;

    localparam int CFG_BITS = $bits(pin_cfg_t);
    localparam int DOUT_BIT = 5;

    typedef struct packed {
        logic cnt0;
        logic cnt1;
        logic hi_rise;
        logic lo_rise;
        logic hi_fall;
        logic lo_fall;
    } route_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin
    import gpio_bank_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     seg_out,
    input  logic     seg_oe,
    output logic     pad_o,
    output logic     pad_en,
    output route_t   route
);
    logic gpio_input;

    always_comb begin
        gpio_input = !cfg.lcd && !cfg.dir;
        route      = '0;
        if (gpio_input) begin
            case (cfg.sel)
                RS_CNT0:    route.cnt0    = 1'b1;
                RS_CNT1:    route.cnt1    = 1'b1;
                RS_HI_RISE: route.hi_rise = 1'b1;
                RS_LO_RISE: route.lo_rise = 1'b1;
                RS_HI_FALL: route.hi_fall = 1'b1;
                RS_LO_FALL: route.lo_fall = 1'b1;
                default:    route         = '0;
            endcase
        end
        if (cfg.lcd) begin
            pad_o  = seg_out;
            pad_en = seg_oe;
        end else begin
            pad_o  = cfg.dout;
            pad_en = cfg.dir;
        end
    end
endmodule

// File: rtl/gpio_bank_route.sv
module gpio_bank_route
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_PINS-1:0]     level,
    input  route_t [NUM_PINS-1:0]   route,
    output logic [1:0]              cnt_clk,
    output logic                    irq_hi,
    output logic                    irq_lo
);
    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic [1:0]          cnt;
        logic                hi;
        logic                lo;
    } route_st_t;

    route_st_t st_d, st_q;
    logic [NUM_PINS-1:0] rise, fall;

    always_comb begin
        rise      = level & ~st_q.prev;
        fall      = ~level & st_q.prev;
        st_d      = st_q;
        st_d.prev = level;
        st_d.cnt  = '0;
        st_d.hi   = 1'b0;
        st_d.lo   = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            st_d.cnt[0] = st_d.cnt[0] | (level[i] & route[i].cnt0);
            st_d.cnt[1] = st_d.cnt[1] | (level[i] & route[i].cnt1);
            st_d.hi     = st_d.hi | (rise[i] & route[i].hi_rise)
                                  | (fall[i] & route[i].hi_fall);
            st_d.lo     = st_d.lo | (rise[i] & route[i].lo_rise)
                                  | (fall[i] & route[i].lo_fall);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_clk = st_q.cnt;
    assign irq_hi  = st_q.hi;
    assign irq_lo  = st_q.lo;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter  int NUM_PINS = 8,
    localparam int ADDR_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [5:0]          wr_data,
    input  logic [5:0]          wr_mask,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [5:0]          rd_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    input  logic [NUM_PINS-1:0] lcd_seg_out,
    input  logic [NUM_PINS-1:0] lcd_seg_oe,
    output logic [1:0]          cnt_clk,
    output logic                irq_hi,
    output logic                irq_lo
);
    localparam int FLAT_W = NUM_PINS * CFG_BITS;

    typedef struct packed {
        pin_cfg_t [NUM_PINS-1:0] cfg;
    } bank_st_t;

    bank_st_t regs_d, regs_q;
    logic [NUM_PINS-1:0]   level;
    route_t [NUM_PINS-1:0] route_vec;
    logic [FLAT_W-1:0]     cfg_flat;

    gpio_bank_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (level)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        gpio_bank_pin u_pin (
            .cfg     (regs_q.cfg[g]),
            .seg_out (lcd_seg_out[g]),
            .seg_oe  (lcd_seg_oe[g]),
            .pad_o   (pad_out[g]),
            .pad_en  (pad_oe[g]),
            .route   (route_vec[g])
        );
    end

    gpio_bank_route #(.NUM_PINS(NUM_PINS)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level),
        .route   (route_vec),
        .cnt_clk (cnt_clk),
        .irq_hi  (irq_hi),
        .irq_lo  (irq_lo)
    );

    always_comb begin
        logic [CFG_BITS-1:0] merged;
        regs_d = regs_q;
        merged = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                merged = (regs_q.cfg[i] & ~wr_mask) | (wr_data & wr_mask);
                regs_d.cfg[i] = pin_cfg_t'(merged);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        pin_cfg_t sel_cfg;
        logic     sel_lvl;
        sel_cfg = '0;
        sel_lvl = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                sel_cfg = regs_q.cfg[i];
                sel_lvl = level[i];
            end
        end
        rd_data           = sel_cfg;
        rd_data[DOUT_BIT] = sel_cfg.dir ? sel_cfg.dout : sel_lvl;
    end

    assign cfg_flat = regs_q.cfg;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [5:0]                    wr_mask,
    input logic [NUM_PINS-1:0]           pad_oe,
    input logic [NUM_PINS-1:0]           lcd_seg_oe,
    input logic [1:0]                    cnt_clk,
    input logic                          irq_hi,
    input logic                          irq_lo,
    input logic [NUM_PINS*CFG_BITS-1:0]  cfg_flat,
    input route_t [NUM_PINS-1:0]         route_vec
);
    logic [NUM_PINS-1:0] in_mask, routed, en_c0, en_c1, en_hi, en_lo;

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            in_mask[i] = !cfg_flat[i*CFG_BITS+4] && !cfg_flat[i*CFG_BITS+3];
            routed[i]  = route_vec[i] != '0;
            en_c0[i]   = route_vec[i].cnt0;
            en_c1[i]   = route_vec[i].cnt1;
            en_hi[i]   = route_vec[i].hi_rise | route_vec[i].hi_fall;
            en_lo[i]   = route_vec[i].lo_rise | route_vec[i].lo_fall;
        end
    end

    a_r1_inputs_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && cnt_clk == '0 && !irq_hi && !irq_lo));

    a_r4_empty_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mask == '0) |=> $stable(cfg_flat));

    a_r3_oe_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pad_oe) |-> ($past(wr_en) || !$stable(lcd_seg_oe)));

    a_r6_cnt0_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clk[0] |-> $past(|en_c0));

    a_r6_cnt1_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clk[1] |-> $past(|en_c1));

    a_r7_hi_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> $past(|en_hi));

    a_r8_lo_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> $past(|en_lo));

    a_r11_route_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
        (routed & ~in_mask) == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_mask    (wr_mask),
    .pad_oe     (pad_oe),
    .lcd_seg_oe (lcd_seg_oe),
    .cnt_clk    (cnt_clk),
    .irq_hi     (irq_hi),
    .irq_lo     (irq_lo),
    .cfg_flat   (cfg_flat),
    .route_vec  (route_vec)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 8;
    localparam int AW         = 3;
    localparam int WD_CYCLES  = 100000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [5:0]    wr_data, wr_mask;
    logic [AW-1:0] rd_addr;
    logic [5:0]    rd_data;
    logic [NP-1:0] pad_in, pad_out, pad_oe, lcd_seg_out, lcd_seg_oe;
    logic [1:0]    cnt_clk;
    logic          irq_hi, irq_lo;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .lcd_seg_out(lcd_seg_out), .lcd_seg_oe(lcd_seg_oe),
        .cnt_clk(cnt_clk), .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [5:0] d, input logic [5:0] m);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_mask = m;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = AW'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic chk_res(input string req, input int c, input int h, input int l);
        chk(req, int'(cnt_clk), c);
        chk(req, int'(irq_hi), h);
        chk(req, int'(irq_lo), l);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_mask = '0;
        rd_addr = '0; pad_in = '0; lcd_seg_out = '0; lcd_seg_oe = '0;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        for (int p = 0; p < NP; p++) begin
            rd(p, v);
            chk("R1 word", v, 0);
        end
        chk("R1 oe", int'(pad_oe), 0);
        chk_res("R1 res", 0, 0, 0);

        // R3: output pin with data 1; R5: stored value read back
        wr(2, 6'b101000, 6'h3F);
        chk("R3 oe", int'(pad_oe), 32'h04);
        chk("R3 out", int'(pad_out), 32'h04);
        rd(2, v);
        chk("R5 stored", v, 40);

        // R4: clear data bit only, direction kept
        wr(2, 6'b000000, 6'b100000);
        chk("R4 oe kept", int'(pad_oe), 32'h04);
        chk("R4 out cleared", int'(pad_out), 0);
        wr(2, 6'h3F, 6'h00);
        rd(2, v);
        chk("R4 empty mask", v, 8);
        chk("R4 empty mask out", int'(pad_out), 0);

        // R5: input level after two synchroniser edges
        pad_in[3] = 1'b1;
        step(1);
        rd(3, v);
        chk("R5 sync lag", v, 0);
        step(1);
        rd(3, v);
        chk("R5 level", v, 32);
        pad_in[3] = 1'b0;
        step(3);

        // R2: LCD pin follows segment driver, selector ignored
        wr(4, 6'b010100, 6'h3F);
        lcd_seg_out[4] = 1'b1; lcd_seg_oe[4] = 1'b1;
        #1;
        chk("R2 oe", int'(pad_oe[4]), 1);
        chk("R2 out", int'(pad_out[4]), 1);
        pad_in[4] = 1'b1;
        for (int k = 0; k < 5; k++) begin
            step(1);
            chk("R2 no irq", int'(irq_hi), 0);
        end
        lcd_seg_oe[4] = 1'b0;
        #1;
        chk("R2 oe off", int'(pad_oe[4]), 0);
        pad_in[4] = 1'b0;
        wr(4, 6'b0, 6'h3F);
        wr(2, 6'b0, 6'h3F);
        step(4);

        // R6..R9 sweep: every selector on every pin
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < 8; s++) begin
                int ec;
                ec = (s == 2) ? 1 : (s == 3) ? 2 : 0;
                wr(p, 6'(s), 6'h3F);
                pad_in[p] = 1'b1;
                step(2);
                chk_res("R6 R7 early", 0, 0, 0);
                step(1);
                chk_res((s < 2) ? "R9 rise" : "R6 R7 rise", ec,
                        (s == 4) ? 1 : 0, (s == 5) ? 1 : 0);
                step(1);
                chk_res("R7 one cycle", ec, 0, 0);
                pad_in[p] = 1'b0;
                step(3);
                chk_res((s < 2) ? "R9 fall" : "R6 R8 fall", 0,
                        (s == 6) ? 1 : 0, (s == 7) ? 1 : 0);
                step(1);
                chk_res("R8 one cycle", 0, 0, 0);
                wr(p, 6'b0, 6'h3F);
            end
        end

        // R10: OR-combining
        wr(1, 6'd2, 6'h3F);
        wr(6, 6'd2, 6'h3F);
        pad_in[6] = 1'b1;
        step(3);
        chk("R10 cnt via pin6", int'(cnt_clk), 1);
        pad_in[6] = 1'b0; pad_in[1] = 1'b1;
        step(3);
        chk("R10 cnt via pin1", int'(cnt_clk), 1);
        pad_in[1] = 1'b0;
        step(3);
        chk("R10 cnt low", int'(cnt_clk), 0);
        wr(1, 6'd5, 6'h3F);
        wr(6, 6'd5, 6'h3F);
        pad_in[1] = 1'b1; pad_in[6] = 1'b1;
        step(3);
        chk("R10 joint pulse", int'(irq_lo), 1);
        step(1);
        chk("R10 single pulse", int'(irq_lo), 0);
        pad_in[1] = 1'b0; pad_in[6] = 1'b0;
        wr(1, 6'b0, 6'h3F);
        wr(6, 6'b0, 6'h3F);
        step(4);

        // R11: output pin routes nothing
        wr(0, 6'b001010, 6'h3F);
        pad_in[0] = 1'b1;
        step(4);
        chk("R11 cnt", int'(cnt_clk), 0);
        wr(0, 6'b001100, 6'h3F);
        pad_in[0] = 1'b0;
        step(2);
        pad_in[0] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step(1);
            chk("R11 irq", int'(irq_hi), 0);
        end

        // R1: reset in mid-run clears driven pins
        wr(5, 6'b101000, 6'h3F);
        chk("R1 pre", int'(pad_oe), 32'h21);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R1 mid reset oe", int'(pad_oe), 0);
        rd(5, v);
        chk("R1 mid reset word", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule